// File: doc/BRIEF.md
# Successive-Approximation Read-Path Accelerator

This block sits on a CPU I/O bus in front of a 6-bit DAC code register and turns ordinary read-modify-write instructions aimed at that register into the steps of a successive-approximation conversion. There is no autonomous conversion engine. Each time the CPU reads the DAC register while the accelerator is enabled, the block rewrites the returned data as it passes. It settles the bit that was on trial during the previous step, using the comparator level seen during this read. It also raises the next lower bit as the new trial. The CPU writes the value back unchanged, and that write-back updates the DAC.

The DAC register lives inside the block, so the block also answers writes to it. Reads of other addresses take their data from the rest of the bus, and the block forwards that data untouched. An internal step counter chooses which two code bits a read acts on. A `start` pulse restarts the sequence. Seven accelerated reads settle all six bits and raise a done flag. A wider result needs several passes, each run by software.

Top module: `sar_bus_accel`

## Requirements
- R1: After reset the DAC register holds 0, `sar_done` is low, and the step counter is idle, so the next accelerated read acts as a first read.
- R2: The first accelerated read of a sequence returns the code field (bits 5:0) as 6'b100000, with bit 5 as the trial bit and the other code bits at 0.
- R3: Accelerated reads two to six each leave the previous trial bit as it is when the effective comparator is high and clear it when it is low. Each of these reads also sets the next lower code bit to 1. No other code bit changes.
- R4: The seventh accelerated read settles bit 0 and sets no new trial. On the clock edge that ends this read, `sar_done` rises and the counter returns to idle. With a comparator that reports input >= DAC, the final code equals the input level.
- R5: When `cmp_invert` is 1, the effective comparator is the complement of `cmp_in`.
- R6: A read of any address other than the DAC address returns `io_rdata_in` unchanged and does not advance the step counter.
- R7: A read of the DAC address while `enable` is low returns the register value unmodified and does not advance the step counter.
- R8: A write strobe at the DAC address stores all data bits of `io_wdata` into the register. Writes to other addresses leave the register unchanged.
- R9: A `start` pulse returns the counter to idle and clears `sar_done`. It takes priority over an accelerated read in the same cycle.
- R10: Register bits outside the code field (bits 7:6) pass through every accelerated read unchanged.
- R11: `sar_done` stays high until the first accelerated read of the next sequence, and it clears on the edge that ends that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows read-data rewriting and counter advance |
| start | input | 1 | Pulse that restarts the sequence |
| cmp_in | input | 1 | Comparator level, high when input >= DAC output |
| cmp_invert | input | 1 | Inverts the comparator sense |
| io_addr | input | 8 | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata_in | input | 8 | Read data from other bus targets |
| io_rdata | output | 8 | Read data returned to the CPU |
| dac_q | output | 8 | DAC register contents (code in bits 5:0) |
| sar_done | output | 1 | High once a sequence has settled all six bits |

## Verification
The in-RTL assertions check these properties on every cycle:
- the counter never leaves its legal range and steps by one on each accelerated read;
- `sar_done` rises only after the final step;
- `start` always clears the sequence;
- an accelerated read changes at most two bits of the register value and never touches the bits outside the code field;
- reads of foreign addresses, and disabled reads, return data unmodified.

Only the bench scenarios can show that a complete sequence converges to the right code for several input levels and with both comparator senses. The same holds for restarting mid-sequence, for foreign and disabled reads interleaved with a running sequence, and for `sar_done` staying high until the next sequence begins.

// File: rtl/sar_accel_pkg.sv
package sar_accel_pkg;

   // Width of a counter that must hold the values 0 .. n
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

   // Mask with ones over [lsb +: width] inside a data word of dw bits
   function automatic logic [63:0] field_mask(input int unsigned lsb,
                                              input int unsigned width);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = 0; i < width; i++) m[lsb + i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/sar_step_ctr.sv
module sar_step_ctr #(
   parameter int unsigned CODE_W = 6,
   localparam int unsigned STEP_W = sar_accel_pkg::cnt_width(CODE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              adv,
   output logic [STEP_W-1:0] step,
   output logic              done
);

   localparam logic [STEP_W-1:0] LAST = STEP_W'(CODE_W);

   logic last_step;
   assign last_step = (step == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= '0;
         done <= 1'b0;
      end else if (start) begin
         step <= '0;
         done <= 1'b0;
      end else if (adv) begin
         if (last_step) begin
            step <= '0;
            done <= 1'b1;
         end else begin
            step <= step + 1'b1;
            if (step == '0) done <= 1'b0;
         end
      end
   end

   // R4
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step <= LAST);

   // R3
   step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !start && !last_step) |=> (step == $past(step) + 1'b1));

   // R6
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !start) |=> $stable(step));

   // R4
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(step) == LAST && $past(adv)));

   // R9
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (step == '0 && !done));

   // R11
   done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> ($past(start) || ($past(adv) && $past(step) == '0)));

endmodule

// File: rtl/sar_bit_mask.sv
module sar_bit_mask #(
   parameter int unsigned CODE_W = 6,
   localparam int unsigned STEP_W = sar_accel_pkg::cnt_width(CODE_W)
) (
   input  logic [STEP_W-1:0] step,
   output logic              first,
   output logic [CODE_W-1:0] res_mask,
   output logic [CODE_W-1:0] trial_mask
);

   assign first = (step == '0);

   for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      // bit i is settled on step CODE_W - i, and put on trial one step earlier
      localparam logic [STEP_W-1:0] RES_S   = STEP_W'(CODE_W - i);
      localparam logic [STEP_W-1:0] TRIAL_S = STEP_W'(CODE_W - 1 - i);
      assign res_mask[i]   = (step == RES_S);
      assign trial_mask[i] = (step == TRIAL_S);
   end

   // R3
   mask_onehot_chk: assert final ($onehot0(res_mask) && $onehot0(trial_mask));

endmodule

// File: rtl/sar_data_merge.sv
module sar_data_merge #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned CODE_LSB = 0
) (
   input  logic [DATA_W-1:0] raw,
   input  logic              apply,
   input  logic              first,
   input  logic              keep,
   input  logic [CODE_W-1:0] res_mask,
   input  logic [CODE_W-1:0] trial_mask,
   output logic [DATA_W-1:0] merged
);

   localparam int unsigned CODE_MSB = CODE_LSB + CODE_W - 1;

   logic [CODE_W-1:0] code_in;
   logic [CODE_W-1:0] code_out;
   logic [CODE_W-1:0] drop;

   assign code_in = raw[CODE_MSB:CODE_LSB];
   assign drop    = res_mask & {CODE_W{~keep}};

   always_comb begin
      if (first) code_out = trial_mask;
      else       code_out = (code_in & ~drop) | trial_mask;
   end

   // lower pass-through slice exists only when the code field is offset
   if (CODE_LSB > 0) begin : g_low
      assign merged[CODE_LSB-1:0] = raw[CODE_LSB-1:0];
   end

   // upper pass-through slice exists only when the field stops short of the top
   if (CODE_MSB < DATA_W - 1) begin : g_high
      assign merged[DATA_W-1:CODE_MSB+1] = raw[DATA_W-1:CODE_MSB+1];
   end

   assign merged[CODE_MSB:CODE_LSB] = apply ? code_out : code_in;

endmodule

// File: rtl/sar_bus_accel.sv
module sar_bus_accel #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned CODE_LSB = 0,
   parameter logic [ADDR_W-1:0] DAC_ADDR = 8'h3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              start,
   input  logic              cmp_in,
   input  logic              cmp_invert,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] io_rdata_in,
   output logic [DATA_W-1:0] io_rdata,
   output logic [DATA_W-1:0] dac_q,
   output logic              sar_done
);

   localparam int unsigned STEP_W = sar_accel_pkg::cnt_width(CODE_W);
   localparam logic [DATA_W-1:0] CODE_MASK =
      DATA_W'(sar_accel_pkg::field_mask(CODE_LSB, CODE_W));

   if (CODE_W < 2) begin : g_bad_code
      $error("CODE_W must be at least 2");
   end
   if (CODE_LSB + CODE_W > DATA_W) begin : g_bad_field
      $error("code field does not fit in the data word");
   end
   if (DATA_W > 64) begin : g_bad_data
      $error("DATA_W above 64 is not supported");
   end

   logic              hit;
   logic              accel_rd;
   logic              keep;
   logic              first;
   logic [STEP_W-1:0] step;
   logic [CODE_W-1:0] res_mask;
   logic [CODE_W-1:0] trial_mask;
   logic [DATA_W-1:0] merged;

   assign hit      = (io_addr == DAC_ADDR);
   assign accel_rd = io_rd && hit && enable;
   assign keep     = cmp_in ^ cmp_invert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             dac_q <= '0;
      else if (io_wr && hit)  dac_q <= io_wdata;
   end

   sar_step_ctr #(.CODE_W(CODE_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .adv   (accel_rd),
      .step  (step),
      .done  (sar_done)
   );

   sar_bit_mask #(.CODE_W(CODE_W)) u_mask (
      .step       (step),
      .first      (first),
      .res_mask   (res_mask),
      .trial_mask (trial_mask)
   );

   sar_data_merge #(
      .DATA_W   (DATA_W),
      .CODE_W   (CODE_W),
      .CODE_LSB (CODE_LSB)
   ) u_merge (
      .raw        (dac_q),
      .apply      (accel_rd),
      .first      (first),
      .keep       (keep),
      .res_mask   (res_mask),
      .trial_mask (trial_mask),
      .merged     (merged)
   );

   assign io_rdata = hit ? merged : io_rdata_in;

   // R6
   foreign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !hit) |-> (io_rdata == io_rdata_in));

   // R7
   disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && hit && !enable) |-> (io_rdata == dac_q));

   // R10
   outside_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accel_rd |-> ((io_rdata & ~CODE_MASK) == (dac_q & ~CODE_MASK)));

   // R3
   two_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accel_rd && step != '0) |-> ($countones(io_rdata ^ dac_q) <= 2));

   // R8
   write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit) |=> (dac_q == $past(io_wdata)));

endmodule

// File: tb/tb_sar_bus_accel.sv
module tb_sar_bus_accel;

   localparam logic [7:0] DAC = 8'h3C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0, start = 1'b0, cmp_in = 1'b0, cmp_invert = 1'b0;
   logic [7:0] io_addr = 8'h00;
   logic       io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0] io_wdata = 8'h00, io_rdata_in = 8'h00;
   logic [7:0] io_rdata, dac_q;
   logic       sar_done;

   always #10 clk = ~clk;

   sar_bus_accel dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
      .cmp_in(cmp_in), .cmp_invert(cmp_invert), .io_addr(io_addr),
      .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
      .io_rdata_in(io_rdata_in), .io_rdata(io_rdata), .dac_q(dac_q),
      .sar_done(sar_done)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // behavioural reference state
   int         m_step = 0;
   bit         m_done = 0;
   logic [7:0] m_reg = 8'h00;
   logic [7:0] last_rd;

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] model_rdata(input logic rd, input logic en,
      input logic keep, input logic [7:0] addr, input logic [7:0] rin);
      logic [7:0] v;
      if (addr != DAC) return rin;
      v = m_reg;
      if (rd && en) begin
         if (m_step == 0) v[5:0] = 6'b100000;
         else begin
            if (!keep) v[6 - m_step] = 1'b0;
            if (m_step < 6) v[5 - m_step] = 1'b1;
         end
      end
      return v;
   endfunction

   // one bus cycle: drive after the falling edge, compare before the rising edge
   task automatic cycle(input string req, input logic rd, input logic wr,
                        input logic st, input logic en, input logic inv,
                        input logic cmp, input logic [7:0] addr,
                        input logic [7:0] wdata, input logic [7:0] rin);
      logic [7:0] exp_rd;
      bit accel;
      io_rd = rd; io_wr = wr; start = st; enable = en; cmp_invert = inv;
      cmp_in = cmp; io_addr = addr; io_wdata = wdata; io_rdata_in = rin;
      exp_rd = model_rdata(rd, en, cmp ^ inv, addr, rin);
      #5;
      check(req, "io_rdata", io_rdata, exp_rd);
      check(req, "dac_q", dac_q, m_reg);
      check(req, "sar_done", {7'b0, sar_done}, {7'b0, m_done});
      last_rd = io_rdata;
      @(posedge clk);
      accel = rd && en && (addr == DAC);
      if (st) begin
         m_step = 0; m_done = 0;
      end else if (accel) begin
         if (m_step == 6) begin m_step = 0; m_done = 1; end
         else begin
            if (m_step == 0) m_done = 0;
            m_step++;
         end
      end
      if (wr && addr == DAC) m_reg = wdata;
      @(negedge clk);
      io_rd = 0; io_wr = 0; start = 0;
   endtask

   task automatic idle(input string req);
      cycle(req, 0, 0, 0, enable, cmp_invert, 0, 8'h00, 8'h00, 8'h5A);
   endtask

   // one read-modify-write step against an analog level vin
   task automatic rmw(input string req, input int vin, input logic inv);
      logic raw;
      raw = (vin >= int'(m_reg[5:0]));
      cycle(req, 1, 0, 0, 1, inv, raw ^ inv, DAC, 8'h00, 8'hEE);
      cycle(req, 0, 1, 0, 1, inv, 0, DAC, last_rd, 8'h00);
   endtask

   task automatic convert(input string req, input int vin, input logic inv,
                          input logic [1:0] upper);
      cycle("R8", 0, 1, 0, 1, inv, 0, DAC, {upper, 6'h15}, 8'h00);
      cycle("R9", 0, 0, 1, 1, inv, 0, 8'h00, 8'h00, 8'h00);
      for (int k = 0; k < 7; k++) rmw(req, vin, inv);
      check(req, "final code", {2'b00, dac_q[5:0]}, 8'(vin));
      check("R10", "upper bits", {6'b0, dac_q[7:6]}, {6'b0, upper});
      check("R4", "done", {7'b0, sar_done}, 8'h01);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, held while reset is asserted
      check("R1", "reset dac_q", dac_q, 8'h00);
      check("R1", "reset done", {7'b0, sar_done}, 8'h00);
      rst_n = 1;
      @(negedge clk);
      idle("R1");
      // R2 first read from reset state
      cycle("R2", 1, 0, 0, 1, 0, 1, DAC, 8'h00, 8'h00);
      cycle("R9", 0, 0, 1, 1, 0, 0, 8'h00, 8'h00, 8'h00);

      // R3 R4 full conversions, normal sense
      convert("R3", 42, 0, 2'b10);
      convert("R4", 63, 0, 2'b01);
      convert("R3", 0, 0, 2'b11);
      // R5 inverted comparator sense
      convert("R5", 21, 1, 2'b00);
      convert("R5", 37, 1, 2'b10);

      // R11 done persists over idle and foreign reads, clears on next first read
      idle("R11");
      cycle("R11", 1, 0, 0, 1, 0, 1, 8'h10, 8'h00, 8'hA5);
      cycle("R11", 1, 0, 0, 1, 0, 1, DAC, 8'h00, 8'h00);
      check("R11", "done cleared", {7'b0, sar_done}, 8'h00);

      // R6 R7 foreign and disabled reads mid-sequence do not disturb it
      cycle("R9", 0, 0, 1, 1, 0, 0, 8'h00, 8'h00, 8'h00);
      rmw("R3", 50, 0);
      rmw("R3", 50, 0);
      cycle("R6", 1, 0, 0, 1, 0, 0, 8'h3D, 8'h00, 8'h77);
      cycle("R7", 1, 0, 0, 0, 0, 0, DAC, 8'h00, 8'h00);
      for (int k = 0; k < 5; k++) rmw("R6", 50, 0);
      check("R7", "code after interruptions", {2'b00, dac_q[5:0]}, 8'd50);

      // R8 write to another address is ignored
      cycle("R8", 0, 1, 0, 1, 0, 0, 8'h3B, 8'hFF, 8'h00);
      check("R8", "foreign write", dac_q, m_reg);

      // R9 start beats an accelerated read in the same cycle, mid-sequence
      rmw("R9", 9, 0);
      rmw("R9", 9, 0);
      cycle("R9", 1, 0, 1, 1, 0, 1, DAC, 8'h00, 8'h00);
      cycle("R9", 1, 0, 0, 1, 0, 1, DAC, 8'h00, 8'h00);
      check("R2", "restart first read", {2'b00, last_rd[5:0]}, 8'h20);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule